// File: doc/BRIEF.md
# Scan List Acquisition Sequencer

This block drives a multi-channel analog converter from a programmable list of conversion entries. The host fills the list through byte-wide registers, two byte writes per entry, then selects a pacing clock, a 24-bit pacer divisor and a run mode, and arms the block. Once armed, the block walks the list from its first entry. For each entry it raises a convert request that carries the channel, gain code and differential selection, and it holds that request until the converter answers with a one-cycle done pulse.

Each entry carries a start marker. An entry with the marker set waits for the next pacer tick. An entry without it converts as soon as the previous conversion is complete. If the marker is set on every entry, each conversion is paced. If it is set only on the first entry, each scan is paced and the conversions inside a scan run back to back. In one-shot mode the block stops after the last entry. In continuous mode it wraps to the first entry until the host stops it. Each completed pass flags an end-of-scan event, which can raise an interrupt and is cleared when the host reads the status register.

Top module: `scan_seq`

## Requirements
- R1: A list entry is written as two writes to address 1. The first write is the low byte, whose bit 7 is the start marker. The second write is the high byte, whose bit 6 selects differential, bits 5:4 give the gain code and bits 3:0 give the channel. Conversions follow list order and present these fields on `conv_diff`, `conv_gain` and `conv_chan`. Entries beyond DEPTH are dropped.
- R2: Writing a command (address 7) with bit 5 set empties the list and halts the sequencer. An arm issued while the list is empty leaves the block idle.
- R3: The pacer divisor N is written as three bytes: low at address 4, middle at address 5, high at address 6. Each byte reads back at its own address. Control bits 7:6 (address 2) select the pacer base: 11 = 100 kHz (DIV_100K clocks), 10 = 1 MHz (DIV_1M clocks), 01 = 5 MHz (DIV_5M clocks), 00 = rising edges of `ext_pace`. While the block runs, it produces a pacer tick every N base periods.
- R4: An entry with its start marker set waits for a pacer tick. An entry without it raises `conv_req` on the second clock edge after the previous `conv_done` has been sampled.
- R5: A command with bit 7 set arms the block from the first entry. A command with bit 4 set returns the block to idle and drops `conv_req` at the next edge. Stop wins over arm when both are set in one write.
- R6: With control bit 2 at 0 (one-shot), completing the last entry sets end of scan and returns the block to idle.
- R7: With control bit 2 at 1 (continuous), completing the last entry sets end of scan and resumes at the first entry.
- R8: A read of address 2 returns status: bit 7 idle, bit 6 running, bit 4 end of scan, all other bits 0. The read clears end of scan.
- R9: `irq` is high exactly while end of scan is pending and control bit 4 is set.
- R10: `conv_req` stays high until `conv_done` arrives. A pacer tick that comes while no entry is waiting is held (at most one) for the next start-marked entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (clears end of scan on address 2) |
| addr | input | 4 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from `addr` |
| ext_pace | input | 1 | External pacer input, rising edges counted |
| conv_req | output | 1 | Convert request, held until done |
| conv_chan | output | 4 | Channel of the current entry |
| conv_gain | output | 2 | Gain code of the current entry |
| conv_diff | output | 1 | Differential select of the current entry |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| irq | output | 1 | End-of-scan interrupt |

## Verification
The bench checks that each of the four pacer bases gives the exact spacing between requests. A wrong prescaler or an off-by-one reload in the divisor shows up as a gap that differs from the programmed period. With per-scan pacing it checks the two-cycle chaining of unmarked entries and the 200-cycle spacing of scan starts across a continuous wrap; a sequencer that paced every entry, or that failed to wrap, would break those gaps. It also fills the list past its depth, where a missing bound would overwrite the first entry or run an extra conversion. It checks stop-over-arm precedence and clear-on-read of end of scan, which would otherwise leave `irq` stuck high.

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int DEPTH    = 2048,
  parameter int PW       = 24,
  parameter int DIV_5M   = 10,
  parameter int DIV_1M   = 50,
  parameter int DIV_100K = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_pace,
  output logic       conv_req,
  output logic [3:0] conv_chan,
  output logic [1:0] conv_gain,
  output logic       conv_diff,
  input  logic       conv_done,
  output logic       irq
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PSW = $clog2(DIV_100K + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [3:0] A_LIST = 4'd1, A_CTRL = 4'd2, A_PL = 4'd4,
                         A_PM = 4'd5, A_PH = 4'd6, A_CMD = 4'd7;

  typedef enum logic [1:0] {IDLE, DISPATCH, WAIT, CONV} st_t;

  st_t            st;
  logic [7:0]     ctrl;
  logic [PW-1:0]  div;
  logic [7:0]     lo_hold;
  logic           lo_ok;
  logic [7:0]     mem [DEPTH];
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  idx;
  logic           eos;
  logic [PSW-1:0] pre;
  logic [PW-1:0]  pcnt;
  logic           tick_pend;
  logic           ext_q;

  wire cmd_wr  = wr_en && addr == A_CMD;
  wire do_stop = cmd_wr && wdata[4];
  wire do_rstq = cmd_wr && wdata[5];
  wire do_arm  = cmd_wr && wdata[7] && !do_stop && !do_rstq && st == IDLE && cnt != '0;
  wire halt    = do_stop || do_rstq;
  wire hi_wr   = wr_en && addr == A_LIST && lo_ok;
  wire sts_rd  = rd_en && addr == A_CTRL;
  wire running = st != IDLE;

  wire [7:0] entry = mem[idx];
  wire last = {{(CW-AW){1'b0}}, idx} == cnt - CW'(1);
  wire eos_set = st == CONV && conv_done && last && !halt;

  // pacer base selection
  logic [PSW-1:0] lim;
  always_comb begin
    case (ctrl[7:6])
      2'b11:   lim = PSW'(DIV_100K - 1);
      2'b10:   lim = PSW'(DIV_1M - 1);
      default: lim = PSW'(DIV_5M - 1);
    endcase
  end
  wire ext_rise = ext_pace && !ext_q;
  wire base = (ctrl[7:6] == 2'b00) ? ext_rise : (running && pre == lim);
  wire [PW-1:0] reload = (div == '0) ? '0 : div - PW'(1);
  wire tick = running && base && pcnt == '0;

  // host registers and list fill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; div <= '0; lo_hold <= '0; lo_ok <= 1'b0; cnt <= '0; ext_q <= 1'b0;
    end else begin
      ext_q <= ext_pace;
      if (wr_en) begin
        case (addr)
          A_CTRL: ctrl <= wdata;
          A_PL:   div[7:0]   <= wdata;
          A_PM:   div[15:8]  <= wdata;
          A_PH:   div[PW-1:16] <= wdata[PW-17:0];
          default: ;
        endcase
      end
      if (do_rstq) begin
        cnt <= '0; lo_ok <= 1'b0;
      end else if (wr_en && addr == A_LIST) begin
        if (!lo_ok) begin
          lo_hold <= wdata; lo_ok <= 1'b1;
        end else begin
          lo_ok <= 1'b0;
          if (cnt < FULL) cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hi_wr && cnt < FULL && !do_rstq)
      mem[cnt[AW-1:0]] <= {wdata[6], wdata[5:4], wdata[3:0], lo_hold[7]};
  end

  // pacer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0; pcnt <= '0; tick_pend <= 1'b0;
    end else begin
      if (do_arm || !running || pre == lim) pre <= '0;
      else pre <= pre + PSW'(1);
      if (do_arm) pcnt <= reload;
      else if (running && base) pcnt <= (pcnt == '0) ? reload : pcnt - PW'(1);
      if (do_arm || !running) tick_pend <= 1'b0;
      else if (tick) tick_pend <= 1'b1;
      else if (st == WAIT) tick_pend <= 1'b0;
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; idx <= '0; eos <= 1'b0;
    end else begin
      if (eos_set) eos <= 1'b1;
      else if (sts_rd) eos <= 1'b0;
      if (halt) st <= IDLE;
      else begin
        case (st)
          IDLE:     if (do_arm) begin idx <= '0; st <= DISPATCH; end
          DISPATCH: st <= entry[0] ? WAIT : CONV;
          WAIT:     if (tick_pend) st <= CONV;
          CONV:     if (conv_done) begin
                      if (!last) begin idx <= idx + AW'(1); st <= DISPATCH; end
                      else if (ctrl[2]) begin idx <= '0; st <= DISPATCH; end
                      else st <= IDLE;
                    end
          default:  st <= IDLE;
        endcase
      end
    end
  end

  wire [7:0] status = {st == IDLE, running, 1'b0, eos, 4'b0};
  always_comb begin
    case (addr)
      A_CTRL:  rdata = status;
      A_PL:    rdata = div[7:0];
      A_PM:    rdata = div[15:8];
      A_PH:    rdata = div[PW-1:16];
      default: rdata = '0;
    endcase
  end

  assign conv_req  = st == CONV;
  assign conv_diff = entry[7];
  assign conv_gain = entry[6:5];
  assign conv_chan = entry[4:1];
  assign irq       = eos && ctrl[4];

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  assert_req_has_list_R1: assert property (@(posedge clk) disable iff (!rst_n) conv_req |-> cnt != '0);
  assert_rstq_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_rstq |=> (cnt == '0 && !conv_req));
  assert_stop_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && wdata[4]) |=> (status[7] && !conv_req));
  assert_oneshot_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && last && !ctrl[2] && !halt) |=> (status[7] && status[4]));
  assert_cont_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && last && ctrl[2] && !halt) |=> (status[6] && idx == '0));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (ctrl[4] && status[4]));
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !halt) |=> conv_req);
endmodule

// File: tb/sim_scan_seq.sv
module sim_scan_seq;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, ext_pace = 0, conv_done = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic conv_req, conv_diff, irq;
  logic [3:0] conv_chan;
  logic [1:0] conv_gain;

  scan_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_pace(ext_pace), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_gain(conv_gain), .conv_diff(conv_diff),
    .conv_done(conv_done), .irq(irq));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, nconv = 0, held_bad = 0;
  int lat = 4;
  bit stopping = 0;
  int ts[$];
  logic [6:0] expq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic add_entry(input int c, input int g, input int d, input bit s, input bit keep);
    wr(1, {s, 7'b0});
    wr(1, {1'b0, 1'(d), 2'(g), 4'(c)});
    if (keep) expq.push_back({1'(d), 2'(g), 4'(c)});
  endtask

  task automatic set_div(input int n);
    wr(4, 8'(n)); wr(5, 8'(n >> 8)); wr(6, 8'(n >> 16));
  endtask

  task automatic fresh();
    wr(7, 8'h20);
    repeat (20) @(negedge clk);
    ts.delete(); nconv = 0; expq.delete();
  endtask

  // ADC model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        ts.push_back(cyc);
        nconv++;
        if (expq.size() == 0) chk("R1 unexpected conversion", nconv, 0);
        else begin
          logic [6:0] it;
          it = expq.pop_front();
          chk("R1 entry fields", {conv_diff, conv_gain, conv_chan}, it);
        end
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (!conv_req && !stopping) held_bad++;
        end
        conv_done = 1;
        @(negedge clk);
        conv_done = 0;
      end
    end
  end

  initial begin
    forever begin
      repeat (20) @(negedge clk);
      ext_pace = ~ext_pace;
    end
  end

  task automatic pace_test(input logic [7:0] cv, input int n, input int per, input string tag);
    logic [7:0] r;
    fresh();
    wr(2, cv);
    set_div(n);
    rd(4, r); chk("R3 divisor low readback", r, 8'(n));
    for (int i = 0; i < 3; i++) add_entry(i + 2, i, i & 1, 1'b1, 1'b1);
    wr(7, 8'h80);
    wait (nconv == 3);
    repeat (20) @(negedge clk);
    chk({tag, " gap1"}, ts[1] - ts[0], per);
    chk({tag, " gap2"}, ts[2] - ts[1], per);
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2, r); chk("R8 reset status", r, 8'h80);
    chk("R9 reset irq", irq, 0);
    chk("R5 reset req", conv_req, 0);

    // one-shot, unmarked entries
    fresh();
    wr(2, 8'h10);
    add_entry(3, 1, 0, 0, 1); add_entry(7, 2, 1, 0, 1); add_entry(0, 3, 1, 0, 1);
    wr(7, 8'h80);
    wait (nconv == 3);
    repeat (20) @(negedge clk);
    chk("R4 chained gap", ts[1] - ts[0], lat + 2);
    chk("R1 queue drained", expq.size(), 0);
    chk("R9 irq on eos", irq, 1);
    rd(2, r); chk("R6 one-shot end status", r, 8'h90);
    rd(2, r); chk("R8 eos cleared by read", r, 8'h80);
    chk("R9 irq dropped", irq, 0);

    // reset queue then arm
    fresh();
    add_entry(1, 0, 0, 0, 0);
    wr(7, 8'h20); wr(7, 8'h80);
    repeat (30) @(negedge clk);
    chk("R2 arm on empty list", nconv, 0);
    rd(2, r); chk("R2 idle after empty arm", r, 8'h80);

    // pacer bases
    pace_test(8'h40, 3, 3 * 10, "R3 5MHz base");
    pace_test(8'h80, 2, 2 * 50, "R3 1MHz base");
    pace_test(8'hC0, 1, 500, "R3 100kHz base");
    pace_test(8'h00, 2, 80, "R3 external base");

    // continuous, per-scan pacing
    fresh();
    wr(2, 8'h54);
    set_div(20);
    add_entry(5, 1, 1, 1, 0); add_entry(9, 2, 0, 0, 0); add_entry(14, 3, 1, 0, 0);
    for (int s = 0; s < 2; s++) begin
      expq.push_back({1'b1, 2'd1, 4'd5});
      expq.push_back({1'b0, 2'd2, 4'd9});
      expq.push_back({1'b1, 2'd3, 4'd14});
    end
    wr(7, 8'h80);
    wait (nconv == 4);
    chk("R9 irq while running", irq, 1);
    rd(2, r); chk("R7 running with eos", r, 8'h50);
    rd(2, r); chk("R8 eos cleared while running", r, 8'h40);
    wait (nconv == 6);
    stopping = 1;
    wr(7, 8'h10);
    chk("R5 stop drops request", conv_req, 0);
    rd(2, r); chk("R5 stop returns idle", r, 8'h80);
    repeat (20) @(negedge clk);
    stopping = 0;
    chk("R4 per-scan chained gap", ts[1] - ts[0], lat + 2);
    chk("R7 wrap scan period", ts[3] - ts[0], 200);
    chk("R1 continuous queue drained", expq.size(), 0);

    // stop wins over arm
    ts.delete(); nconv = 0;
    wr(7, 8'h90);
    repeat (30) @(negedge clk);
    chk("R5 stop beats arm", nconv, 0);

    // list overfill
    fresh();
    wr(2, 8'h00);
    for (int i = 0; i <= 2048; i++) add_entry(i % 16, (i / 16) % 4, (i / 64) % 2, 0, i < 2048);
    wr(7, 8'h80);
    wait (nconv == 2048);
    repeat (30) @(negedge clk);
    chk("R1 depth bound conversions", nconv, 2048);
    rd(2, r); chk("R6 end after full list", r, 8'h90);
    chk("R10 request held until done", held_bad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule